// File: doc/BRIEF.md
# Synchronized Clock Stop Gate

This block sits after the clock synthesizer and decides which derived clock outputs toggle. It serves two clock domains. The fast domain drives a processor clock group and a memory clock group. The bus domain drives a bus clock group. Each domain has its own asynchronous, active-low stop request. The block synchronizes that request into the domain's own clock and then opens or closes the gates of that domain. Gates change only while the source clock is low. A stopped output therefore always rests low, and the first pulse after a restart is a full high phase.

Each domain also has free-running outputs that ignore the stop request. Every output, free-running or gated, has its own enable bit from a configuration register. A cleared bit holds that output low whatever the stop request says.

The fast domain stops and restarts with equal latency. The bus domain stops just as quickly but holds off its restart for a further programmable number of bus clock edges.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is low, every output is low by the first rising source edge after one falling edge of that source in reset.
- R2: When `fast_stop_n` falls in the low phase before rising edge k of `clk_fast`, gated processor and memory outputs still pulse on edges k and k+1. From edge k+2 they stay low.
- R3: When `fast_stop_n` rises in the low phase before fast edge k, gated processor and memory outputs are low on edges k and k+1. They pulse again from edge k+2.
- R4: When `bus_stop_n` falls in the low phase before rising edge k of `clk_bus`, gated bus outputs still pulse on edges k and k+1. From edge k+2 they stay low.
- R5: When `bus_stop_n` rises in the low phase before bus edge k, gated bus outputs stay low through edge k+3 (two synchronizer edges plus `BUS_ON_DLY`=2 warm-up edges). Their first pulse is on edge k+4.
- R6: Every high pulse on a gated output lasts exactly one full high phase of its source clock. An output with no pulse rests low.
- R7: `fast_free_o`, `mem_free_o` and `bus_free_o` keep pulsing while their domain's stop request is low.
- R8: Stopping one domain does not interrupt the gated outputs of the other domain.
- R9: An output whose enable bit is 0 stays low and does not switch, whether or not its domain is stopped.
- R10: Bit i of `fast_en`, `mem_en` and `bus_en` controls bit i of `fast_clk_o`, `mem_clk_o` and `bus_clk_o` respectively. An enable change made in a low phase takes effect from the second following rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Internal processor-rate clock |
| clk_bus | input | 1 | Internal bus-rate clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both domains |
| fast_stop_n | input | 1 | Asynchronous request, low stops the processor and memory groups |
| bus_stop_n | input | 1 | Asynchronous request, low stops the bus group |
| fast_en | input | N_FAST | Enable per gated processor output |
| fast_free_en | input | 1 | Enable for the free-running processor output |
| mem_en | input | N_MEM | Enable per gated memory output |
| mem_free_en | input | 1 | Enable for the free-running memory output |
| bus_en | input | N_BUS | Enable per gated bus output |
| bus_free_en | input | 1 | Enable for the free-running bus output |
| fast_clk_o | output | N_FAST | Gated processor clocks |
| fast_free_o | output | 1 | Free-running processor clock |
| mem_clk_o | output | N_MEM | Gated memory clocks |
| mem_free_o | output | 1 | Free-running memory clock |
| bus_clk_o | output | N_BUS | Gated bus clocks |
| bus_free_o | output | 1 | Free-running bus clock |

## Verification
The bench changes each stop request in the middle of a low phase. It then records, edge by edge, which rising edges still carry an output pulse. A missing or extra synchronizer stage shifts that pattern by one edge. A bus restart without the warm-up delay shows a pulse on the third edge instead of the fifth. Every gated pulse width is timed, so a gate that changes while the clock is high is caught as a runt. Two more checks target the enable logic: free-running outputs must keep counting through a stop, and a partial enable pattern must appear bit for bit on the outputs. A swapped mask or a stop that leaks into the free outputs fails these checks.

// File: rtl/cg_pkg.sv
`timescale 1ns/1ps
// Package: shared types of the clock stop gate.
// Assumes: nothing beyond IEEE 1800-2017.
package cg_pkg;
    // Run state of the restart sequencer of one domain.
    typedef enum logic {
        CG_HALT = 1'b0,
        CG_RUN  = 1'b1
    } cg_run_e;
endpackage

// File: rtl/cg_sync2.sv
`timescale 1ns/1ps
// Module: cg_sync2
// Brings an asynchronous level into the clk domain through STAGES flops.
// Assumes: STAGES >= 2; reset drives the output to 0, which reads as "stopped".
module cg_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] pipe_q;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], async_i};
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cg_restart_seq.sv
`timescale 1ns/1ps
// Module: cg_restart_seq
// Turns the synchronized run request into the gate permission of a domain.
// Stopping is immediate. Starting waits ON_DLY further rising edges.
// Assumes: req_run is already synchronous to clk.
module cg_restart_seq
    import cg_pkg::*;
#(
    parameter int ON_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_run,
    output logic allow
);
    generate
        if (ON_DLY == 0) begin : g_direct
            assign allow = req_run;
        end else begin : g_delayed
            localparam int CW = (ON_DLY > 1) ? $clog2(ON_DLY) : 1;
            cg_run_e       state_q;
            logic [CW-1:0] cnt_q;

            // Count warm-up edges after a release, fall back to HALT on any stop.
            always_ff @(posedge clk) begin
                if (!rst_n || !req_run) begin
                    state_q <= CG_HALT;
                    cnt_q   <= '0;
                end else if (state_q == CG_HALT) begin
                    if (cnt_q == CW'(ON_DLY - 1)) state_q <= CG_RUN;
                    else                          cnt_q   <= cnt_q + 1'b1;
                end
            end

            assign allow = req_run && (state_q == CG_RUN);

            // R5: a fresh release never opens the gate on the same edge.
            assert_warmup_R5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(req_run) |-> !allow);
        end
    endgenerate
endmodule

// File: rtl/cg_gate_cell.sv
`timescale 1ns/1ps
// Module: cg_gate_cell
// W glitch-free gated copies of clk. The gate register loads on the
// falling edge, so it is stable for the whole high phase.
// Assumes: en and allow are settled before each falling edge of clk.
module cg_gate_cell #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         allow,
    input  logic [W-1:0] en,
    output logic [W-1:0] clk_o
);
    logic [W-1:0] gate_q;

    // Load the per-output gate while the source clock is low.
    always_ff @(negedge clk) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= en & {W{allow}};
    end

    assign clk_o = gate_q & {W{clk}};

    // R9: an output whose enable was clear during the last low phase stays low.
    assert_masked_low_R9: assert property (@(negedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((clk_o & ~$past(en)) == '0));
endmodule

// File: rtl/cg_domain.sv
`timescale 1ns/1ps
// Module: cg_domain
// One clock domain: a stop-request synchronizer, a restart sequencer, the
// gated outputs and the free-running outputs.
// Assumes: the stop request is asynchronous and stays high for at least
// the minimum run period of the domain.
module cg_domain #(
    parameter int N_GATED = 4,
    parameter int N_FREE  = 1,
    parameter int ON_DLY  = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stop_n,
    input  logic [N_GATED-1:0] gated_en,
    input  logic [N_FREE-1:0]  free_en,
    output logic [N_GATED-1:0] gated_o,
    output logic [N_FREE-1:0]  free_o
);
    logic sync_q;
    logic allow;

    cg_sync2 #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(stop_n),
        .sync_o (sync_q)
    );

    cg_restart_seq #(.ON_DLY(ON_DLY)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_run(sync_q),
        .allow  (allow)
    );

    cg_gate_cell #(.W(N_GATED)) u_gated (
        .clk  (clk),
        .rst_n(rst_n),
        .allow(allow),
        .en   (gated_en),
        .clk_o(gated_o)
    );

    cg_gate_cell #(.W(N_FREE)) u_free (
        .clk  (clk),
        .rst_n(rst_n),
        .allow(1'b1),
        .en   (free_en),
        .clk_o(free_o)
    );

    // R2 and R4: a stop seen on two successive falling edges leaves every gated output low.
    assert_stopped_low_R2: assert property (@(negedge clk) disable iff (!rst_n)
        (!sync_q && !$past(sync_q)) |-> (gated_o == '0));

    // R7: free outputs follow only their enables, never the stop request.
    assert_free_runs_R7: assert property (@(negedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (free_o == $past(free_en)));
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
// Module: clk_stop_gate
// Top: the fast domain gates the processor and memory groups together. The
// bus domain gates the bus group and adds BUS_ON_DLY warm-up edges on restart.
// Assumes: rst_n is held low long enough to span a falling edge of both clocks.
module clk_stop_gate #(
    parameter int N_FAST     = 3,
    parameter int N_MEM      = 8,
    parameter int N_BUS      = 6,
    parameter int BUS_ON_DLY = 2
) (
    input  logic              clk_fast,
    input  logic              clk_bus,
    input  logic              rst_n,
    input  logic              fast_stop_n,
    input  logic              bus_stop_n,
    input  logic [N_FAST-1:0] fast_en,
    input  logic              fast_free_en,
    input  logic [N_MEM-1:0]  mem_en,
    input  logic              mem_free_en,
    input  logic [N_BUS-1:0]  bus_en,
    input  logic              bus_free_en,
    output logic [N_FAST-1:0] fast_clk_o,
    output logic              fast_free_o,
    output logic [N_MEM-1:0]  mem_clk_o,
    output logic              mem_free_o,
    output logic [N_BUS-1:0]  bus_clk_o,
    output logic              bus_free_o
);
    localparam int N_FG = N_FAST + N_MEM;

    logic [N_FG-1:0] fast_gated;
    logic [1:0]      fast_free;

    cg_domain #(.N_GATED(N_FG), .N_FREE(2), .ON_DLY(0)) u_fast (
        .clk     (clk_fast),
        .rst_n   (rst_n),
        .stop_n  (fast_stop_n),
        .gated_en({mem_en, fast_en}),
        .free_en ({mem_free_en, fast_free_en}),
        .gated_o (fast_gated),
        .free_o  (fast_free)
    );

    assign fast_clk_o  = fast_gated[N_FAST-1:0];
    assign mem_clk_o   = fast_gated[N_FG-1:N_FAST];
    assign fast_free_o = fast_free[0];
    assign mem_free_o  = fast_free[1];

    cg_domain #(.N_GATED(N_BUS), .N_FREE(1), .ON_DLY(BUS_ON_DLY)) u_bus (
        .clk     (clk_bus),
        .rst_n   (rst_n),
        .stop_n  (bus_stop_n),
        .gated_en(bus_en),
        .free_en (bus_free_en),
        .gated_o (bus_clk_o),
        .free_o  (bus_free_o)
    );
endmodule

// File: tb/clk_stop_gate_tb_top.sv
`timescale 1ns/1ps
module clk_stop_gate_tb_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  BUS_PERIOD = 3 * CLK_PERIOD;
    localparam int  N_FAST = 3;
    localparam int  N_MEM  = 8;
    localparam int  N_BUS  = 6;

    logic clk_fast = 1'b0;
    logic clk_bus  = 1'b0;
    logic rst_n    = 1'b0;
    logic fast_stop_n = 1'b1;
    logic bus_stop_n  = 1'b1;
    logic [N_FAST-1:0] fast_en = '1;
    logic              fast_free_en = 1'b1;
    logic [N_MEM-1:0]  mem_en = '1;
    logic              mem_free_en = 1'b1;
    logic [N_BUS-1:0]  bus_en = '1;
    logic              bus_free_en = 1'b1;
    logic [N_FAST-1:0] fast_clk_o;
    logic              fast_free_o;
    logic [N_MEM-1:0]  mem_clk_o;
    logic              mem_free_o;
    logic [N_BUS-1:0]  bus_clk_o;
    logic              bus_free_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    int n_fast = 0, n_mem = 0, n_ffree = 0, n_mfree = 0, n_bus = 0, n_bfree = 0;
    int runts = 0;
    realtime t_fast = 0, t_mem = 0, t_bus = 0;

    always #(CLK_PERIOD/2) clk_fast = ~clk_fast;
    always #(BUS_PERIOD/2) clk_bus  = ~clk_bus;

    clk_stop_gate #(.N_FAST(N_FAST), .N_MEM(N_MEM), .N_BUS(N_BUS), .BUS_ON_DLY(2)) dut_i (
        .clk_fast(clk_fast), .clk_bus(clk_bus), .rst_n(rst_n),
        .fast_stop_n(fast_stop_n), .bus_stop_n(bus_stop_n),
        .fast_en(fast_en), .fast_free_en(fast_free_en),
        .mem_en(mem_en), .mem_free_en(mem_free_en),
        .bus_en(bus_en), .bus_free_en(bus_free_en),
        .fast_clk_o(fast_clk_o), .fast_free_o(fast_free_o),
        .mem_clk_o(mem_clk_o), .mem_free_o(mem_free_o),
        .bus_clk_o(bus_clk_o), .bus_free_o(bus_free_o)
    );

    // Pulse counters on the observed outputs.
    always @(posedge fast_clk_o[0]) begin n_fast++;  t_fast = $realtime; end
    always @(posedge mem_clk_o[0])  begin n_mem++;   t_mem  = $realtime; end
    always @(posedge bus_clk_o[0])  begin n_bus++;   t_bus  = $realtime; end
    always @(posedge fast_free_o)   n_ffree++;
    always @(posedge mem_free_o)    n_mfree++;
    always @(posedge bus_free_o)    n_bfree++;

    // R6 pulse-width monitors: each high pulse must span a full source high phase.
    always @(negedge fast_clk_o[0]) if ($realtime - t_fast != CLK_PERIOD/2.0) runts++;
    always @(negedge mem_clk_o[0])  if ($realtime - t_mem  != CLK_PERIOD/2.0) runts++;
    always @(negedge bus_clk_o[0])  if ($realtime - t_bus  != BUS_PERIOD/2.0) runts++;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // R1: outputs low while in reset.
    task automatic t_reset();
        repeat (4) @(posedge clk_bus);
        @(posedge clk_fast); #1;
        check("R1 fast/mem outputs in reset", {fast_clk_o, mem_clk_o, fast_free_o, mem_free_o}, '0);
        @(posedge clk_bus); #1;
        check("R1 bus outputs in reset", {bus_clk_o, bus_free_o}, '0);
        @(negedge clk_bus); rst_n = 1'b1;
        repeat (20) @(posedge clk_bus);
    endtask

    // R2, R3, R7, R8: fast stop and restart latency, isolation.
    task automatic t_fast_stop();
        logic [7:0] seen;
        int b0, f0, m0, x0, mf0;
        @(negedge clk_fast); #(CLK_PERIOD/4);
        fast_stop_n = 1'b0;
        for (int j = 0; j < 6; j++) begin
            @(posedge clk_fast); #1;
            seen[j] = fast_clk_o[0] & (mem_clk_o == mem_en);
        end
        check("R2 fast stop edge pattern", {58'd0, seen[5:0]}, 64'b000011);
        b0 = n_bus; f0 = n_ffree; mf0 = n_mfree; x0 = n_fast; m0 = n_mem;
        repeat (40) @(posedge clk_fast); #1;
        check("R2 gated fast/mem silent while stopped", (n_fast - x0) + (n_mem - m0), 0);
        check("R7 free fast/mem keep running", ((n_ffree - f0) > 30) && ((n_mfree - mf0) > 30), 1);
        check("R8 bus group unaffected by fast stop", (n_bus - b0) > 8, 1);
        @(negedge clk_fast); #(CLK_PERIOD/4);
        fast_stop_n = 1'b1;
        for (int j = 0; j < 6; j++) begin
            @(posedge clk_fast); #1;
            seen[j] = (fast_clk_o == fast_en) && (mem_clk_o == mem_en);
        end
        check("R3 fast restart edge pattern", {58'd0, seen[5:0]}, 64'b111100);
        repeat (110) @(posedge clk_fast);
    endtask

    // R4, R5, R7, R8: bus stop and delayed restart.
    task automatic t_bus_stop();
        logic [7:0] seen;
        int f0, x0, bf0;
        @(negedge clk_bus); #(BUS_PERIOD/4);
        bus_stop_n = 1'b0;
        for (int j = 0; j < 6; j++) begin
            @(posedge clk_bus); #1;
            seen[j] = bus_clk_o[0];
        end
        check("R4 bus stop edge pattern", {58'd0, seen[5:0]}, 64'b000011);
        f0 = n_fast; x0 = n_bus; bf0 = n_bfree;
        repeat (12) @(posedge clk_bus); #1;
        check("R4 gated bus silent while stopped", n_bus - x0, 0);
        check("R7 free bus keeps running", (n_bfree - bf0) >= 11, 1);
        check("R8 fast group unaffected by bus stop", (n_fast - f0) > 30, 1);
        @(negedge clk_bus); #(BUS_PERIOD/4);
        bus_stop_n = 1'b1;
        for (int j = 0; j < 7; j++) begin
            @(posedge clk_bus); #1;
            seen[j] = (bus_clk_o == bus_en);
        end
        check("R5 bus restart edge pattern", {57'd0, seen[6:0]}, 64'b1110000);
        repeat (12) @(posedge clk_bus);
    endtask

    // R9, R10: enable mask ordering and forced-low outputs.
    task automatic t_enable();
        int x0, f0;
        @(negedge clk_fast); #(CLK_PERIOD/4);
        fast_en = 3'b101; mem_en = 8'h5A;
        @(posedge clk_fast); @(posedge clk_fast); #1;
        check("R10 fast mask bit order", fast_clk_o, 3'b101);
        check("R10 mem mask bit order", mem_clk_o, 8'h5A);
        @(negedge clk_bus); #(BUS_PERIOD/4);
        bus_en = 6'b100110;
        @(posedge clk_bus); @(posedge clk_bus); #1;
        check("R10 bus mask bit order", bus_clk_o, 6'b100110);
        @(negedge clk_fast); #(CLK_PERIOD/4);
        fast_free_en = 1'b0; fast_en = 3'b000;
        repeat (2) @(posedge clk_fast);
        x0 = n_fast; f0 = n_ffree;
        repeat (10) @(posedge clk_fast); #1;
        check("R9 disabled gated output silent", n_fast - x0, 0);
        check("R9 disabled free output silent", n_ffree - f0, 0);
        check("R9 disabled output level low", {fast_clk_o, fast_free_o}, '0);
        @(negedge clk_fast); #(CLK_PERIOD/4);
        fast_en = '1; fast_free_en = 1'b1; mem_en = '1;
        @(negedge clk_bus); #(BUS_PERIOD/4);
        bus_en = '1;
        repeat (4) @(posedge clk_bus);
    endtask

    // R6: no runt pulse was seen anywhere in the run.
    task automatic t_runt();
        check("R6 runt pulses on gated outputs", runts, 0);
        check("R6 gated outputs pulsed at all", (n_fast > 0) && (n_mem > 0) && (n_bus > 0), 1);
    endtask

    initial begin
        t_reset();
        t_fast_stop();
        t_bus_stop();
        t_enable();
        t_fast_stop();
        t_runt();
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk_fast);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule